// File: doc/BRIEF.md
# Host I/O Region Decoder

This block takes single byte or word accesses from a 16-bit host processor and steers them into one of two address areas. The lower 64 KB area belongs to a sound coprocessor. It holds a window onto the coprocessor's 8 KB shared RAM, the address and data ports of a sound chip, and a single address that writes the coprocessor's bank register. The upper area is a small system I/O space. It holds a read-only version byte, a data port and a control register for each game controller, a register that requests the coprocessor's bus, and a register that holds the coprocessor in reset.

The host can reach the coprocessor area only after the coprocessor has granted its bus. Until then every read of that area returns all ones and every write is silently discarded. The shared RAM, the sound chip and the controller port logic sit outside the block. Each connects through plain read and write strobes, a shared write byte and a read data input that the block samples in the access cycle. Read data is registered and arrives one cycle after the access.

Top module: `hio_decoder`

## Requirements
- R1: An offset with bits 16 and above clear selects the coprocessor area, where only offset bits 14:0 count. Below 0x4000 the access goes to shared RAM: `ram_re` or `ram_we` pulses with `ram_addr` = offset bits 12:0, and a read returns `ram_rdata`.
- R2: A coprocessor-area access made while `cop_busack` is low raises no strobe. A byte read returns 0x00FF and a word read returns 0xFFFF.
- R3: Coprocessor offsets 0x4000–0x5FFF drive the sound-chip strobes. For a write, `snd_port` is 2 (data) when offset bit 0 is set, 1 (second address port) when bit 0 is clear and bit 1 is set, and 0 (first address port) when both are clear. A read returns `snd_status`.
- R4: Only coprocessor offset 0x6000 (after the 15-bit mask) pulses `bank_we` on a write. Every other offset from 0x6000 to 0x7FFF is unmapped.
- R5: In the I/O area only offset bits 12:0 count. Below 0x100 the index is offset bits 7:1. Index 0 is the version byte. Indices 1–3 are controller data ports 0–2: `pad_re` or `pad_we` bit k pulses and a read returns byte k of `pad_rdata`. Indices 4–6 are the control registers of controllers 0–2, which are readable and writable and are driven on byte k of `pad_ctl`. Any other index reads 0xFF.
- R6: The version byte has bit 5 set for no disk attached and bits 7:6 as the region (10 US, 00 Japan, 11 Europe; bit 6 set means 50 Hz), with bits 4:0 zero. The default is 0xA0.
- R7: A write to I/O offset 0x1100 sets `cop_busreq` to bit 0 of the write byte. A read there returns a byte equal to the inverse of `cop_busack`.
- R8: A write to I/O offset 0x1200 sets `cop_reset` to the inverse of bit 0 of the write byte. A read returns the inverse of `cop_reset`.
- R9: `hst_rvalid` pulses for one cycle, in the cycle after a read. A byte read returns the byte in bits 7:0 with bits 15:8 zero. A word read repeats the byte in both halves for the coprocessor area and for I/O offsets below 0x100. For other I/O offsets it places the byte in bits 15:8 with bits 7:0 zero.
- R10: The write byte `wr_byte` is the low data byte for byte writes and for word writes to I/O offsets below 0x100. It is the high data byte for word writes anywhere else.
- R11: After reset `cop_busreq` is 0, `cop_reset` is 1, every control register is 0, and `hst_rvalid` is 0.
- R12: A write to an unmapped offset changes no register and raises no strobe. A read of an unmapped offset returns the byte 0xFF.
- R13: At most one strobe is active in any cycle, and none is active while `hst_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_valid | input | 1 | Host access in this cycle |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_word | input | 1 | 1 = 16-bit access, 0 = byte |
| hst_addr | input | 17 | Offset into the decoded region |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Registered read data |
| hst_rvalid | output | 1 | Read data valid, one cycle after a read |
| cop_busack | input | 1 | Coprocessor bus grant |
| cop_busreq | output | 1 | Bus request to the coprocessor |
| cop_reset | output | 1 | Coprocessor reset, active high |
| ram_re | output | 1 | Shared RAM read strobe |
| ram_we | output | 1 | Shared RAM write strobe |
| ram_addr | output | 13 | Shared RAM byte address |
| ram_rdata | input | 8 | Shared RAM read byte |
| snd_re | output | 1 | Sound-chip status read strobe |
| snd_we | output | 1 | Sound-chip write strobe |
| snd_port | output | 2 | Sound port: 0 addr part 1, 1 addr part 2, 2 data |
| snd_status | input | 8 | Sound-chip status byte |
| bank_we | output | 1 | Bank register write strobe |
| pad_re | output | 3 | Per-controller data read strobes |
| pad_we | output | 3 | Per-controller data write strobes |
| pad_rdata | input | 24 | Controller data bytes, controller k in byte k |
| pad_ctl | output | 24 | Controller control registers, controller k in byte k |
| wr_byte | output | 8 | Byte delivered with every write strobe |

## Verification
A wrong decode shows up in the access cycle itself as a missing, extra or misplaced strobe, or as a wrong `snd_port` or `wr_byte`. For a read it shows one cycle later in `hst_rdata`. A bad bus-request or reset register shows on `cop_busreq` or `cop_reset` right after the clock edge that took the write, and again in the next read of that register. A corrupted control register stays hidden until `pad_ctl` is observed or the register is read back. For that reason every control write in the bench is followed by a port observation and a readback. The bus-grant gate is tested with the grant both low and high at the same offsets, so that a leak in either direction becomes visible.

// File: rtl/hio_pkg.sv
// Shared types for the host I/O region decoder.
// Assumes: one access target is chosen per cycle; TG_NONE must stay code 0.
package hio_pkg;

    typedef enum logic [3:0] {
        TG_NONE  = 4'd0,
        TG_RAM   = 4'd1,
        TG_SND   = 4'd2,
        TG_BANK  = 4'd3,
        TG_VER   = 4'd4,
        TG_PDATA = 4'd5,
        TG_PCTL  = 4'd6,
        TG_BREQ  = 4'd7,
        TG_CRST  = 4'd8
    } hio_tgt_e;

    typedef enum logic [1:0] {
        SP_ADDR1 = 2'd0,
        SP_ADDR2 = 2'd1,
        SP_DATA  = 2'd2
    } snd_port_e;

    typedef struct packed {
        hio_tgt_e  tgt;
        logic      mirror;
        logic      hi_byte;
        snd_port_e port;
    } hio_dec_t;

    localparam logic [7:0] HIO_FILL = 8'hFF;

endpackage

// File: rtl/hio_addr_decode.sv
// Address decoder: maps a host offset to one target and a controller index.
// Assumes: ADDR_W >= 17 and bus grant is sampled combinationally in the access cycle.
module hio_addr_decode
    import hio_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int NUM_PADS = 3,
    parameter int PIDX_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              busack,
    output hio_dec_t          dec,
    output logic [PIDX_W-1:0] pad_sel
);

    localparam logic [6:0] NP_LO = 7'(NUM_PADS);
    localparam logic [6:0] NP_HI = 7'(2 * NUM_PADS);

    logic        in_cop;
    logic [14:0] cop_off;
    logic [12:0] io_off;
    logic [6:0]  idx;

    assign in_cop  = (addr[ADDR_W-1:16] == '0);
    assign cop_off = addr[14:0];
    assign io_off  = addr[12:0];
    assign idx     = io_off[7:1];

    // Pick the target, the read-format flags and the sound port from the offset.
    always_comb begin
        dec     = '{tgt: TG_NONE, mirror: 1'b0, hi_byte: 1'b0, port: SP_ADDR1};
        pad_sel = '0;
        if (in_cop) begin
            dec.mirror  = 1'b1;
            dec.hi_byte = 1'b1;
            if (busack) begin
                if (cop_off < 15'h4000) begin
                    dec.tgt = TG_RAM;
                end else if (cop_off < 15'h6000) begin
                    dec.tgt = TG_SND;
                    if (cop_off[0])      dec.port = SP_DATA;
                    else if (cop_off[1]) dec.port = SP_ADDR2;
                    else                 dec.port = SP_ADDR1;
                end else if (cop_off == 15'h6000) begin
                    dec.tgt = TG_BANK;
                end
            end
        end else if (io_off < 13'h0100) begin
            dec.mirror = 1'b1;
            if (idx == 7'd0) begin
                dec.tgt = TG_VER;
            end else if (idx <= NP_LO) begin
                dec.tgt = TG_PDATA;
                pad_sel = PIDX_W'(idx - 7'd1);
            end else if (idx <= NP_HI) begin
                dec.tgt = TG_PCTL;
                pad_sel = PIDX_W'(idx - NP_LO - 7'd1);
            end
        end else begin
            dec.hi_byte = 1'b1;
            if (io_off == 13'h1100)      dec.tgt = TG_BREQ;
            else if (io_off == 13'h1200) dec.tgt = TG_CRST;
        end
    end

endmodule

// File: rtl/hio_ctrl_regs.sv
// Writable state: coprocessor bus request, coprocessor reset, controller control bytes.
// Assumes: wr_en is already qualified by a valid host write; tgt comes from the decoder.
module hio_ctrl_regs
    import hio_pkg::*;
#(
    parameter int NUM_PADS = 3,
    parameter int PIDX_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  hio_tgt_e              tgt,
    input  logic [PIDX_W-1:0]     pad_sel,
    input  logic [7:0]            wr_byte,
    output logic                  busreq,
    output logic                  cop_rst,
    output logic [NUM_PADS*8-1:0] ctl_flat
);

    // Bus request follows bit 0 of a write to its register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         busreq <= 1'b0;
        else if (wr_en && tgt == TG_BREQ)   busreq <= wr_byte[0];
    end

    // Reset is held until a write with bit 0 set releases it.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cop_rst <= 1'b1;
        else if (wr_en && tgt == TG_CRST)   cop_rst <= ~wr_byte[0];
    end

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_ctl
        // Control byte of controller g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_flat[g*8 +: 8] <= 8'h00;
            else if (wr_en && tgt == TG_PCTL && pad_sel == PIDX_W'(g))
                ctl_flat[g*8 +: 8] <= wr_byte;
        end
    end

endmodule

// File: rtl/hio_read_path.sv
// Read path: selects the byte for the decoded target and formats it on the 16-bit bus.
// Assumes: external read data is valid in the access cycle; result appears one cycle later.
module hio_read_path
    import hio_pkg::*;
#(
    parameter int         NUM_PADS = 3,
    parameter int         PIDX_W   = 2,
    parameter logic [7:0] VER_BYTE = 8'hA0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  word,
    input  hio_tgt_e              tgt,
    input  logic                  mirror,
    input  logic [PIDX_W-1:0]     pad_sel,
    input  logic [7:0]            ram_rdata,
    input  logic [7:0]            snd_status,
    input  logic [NUM_PADS*8-1:0] pad_rdata,
    input  logic [NUM_PADS*8-1:0] ctl_flat,
    input  logic                  busack,
    input  logic                  cop_rst,
    output logic [15:0]           rdata,
    output logic                  rvalid
);

    logic [7:0]  rd_byte;
    logic [15:0] rd_word;

    // Byte selected by the decoded target.
    always_comb begin
        unique case (tgt)
            TG_RAM:   rd_byte = ram_rdata;
            TG_SND:   rd_byte = snd_status;
            TG_VER:   rd_byte = VER_BYTE;
            TG_PDATA: rd_byte = pad_rdata[int'(pad_sel)*8 +: 8];
            TG_PCTL:  rd_byte = ctl_flat[int'(pad_sel)*8 +: 8];
            TG_BREQ:  rd_byte = {7'd0, ~busack};
            TG_CRST:  rd_byte = {7'd0, ~cop_rst};
            default:  rd_byte = HIO_FILL;
        endcase
    end

    // Place the byte on the bus by access size and region.
    always_comb begin
        if (!word)       rd_word = {8'h00, rd_byte};
        else if (mirror) rd_word = {rd_byte, rd_byte};
        else             rd_word = {rd_byte, 8'h00};
    end

    // Register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= 16'h0000;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_word;
        end
    end

endmodule

// File: rtl/hio_decoder.sv
// Top: host byte/word access decoder for the coprocessor area and the system I/O area.
// Assumes: one access per hst_valid cycle; strobes are combinational in that cycle.
module hio_decoder
    import hio_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter int         NUM_PADS = 3,
    parameter int         RAM_AW   = 13,
    parameter logic [1:0] REGION   = 2'b10,
    parameter logic       NO_DISK  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hst_valid,
    input  logic                  hst_write,
    input  logic                  hst_word,
    input  logic [ADDR_W-1:0]     hst_addr,
    input  logic [15:0]           hst_wdata,
    output logic [15:0]           hst_rdata,
    output logic                  hst_rvalid,
    input  logic                  cop_busack,
    output logic                  cop_busreq,
    output logic                  cop_reset,
    output logic                  ram_re,
    output logic                  ram_we,
    output logic [RAM_AW-1:0]     ram_addr,
    input  logic [7:0]            ram_rdata,
    output logic                  snd_re,
    output logic                  snd_we,
    output logic [1:0]            snd_port,
    input  logic [7:0]            snd_status,
    output logic                  bank_we,
    output logic [NUM_PADS-1:0]   pad_re,
    output logic [NUM_PADS-1:0]   pad_we,
    input  logic [NUM_PADS*8-1:0] pad_rdata,
    output logic [NUM_PADS*8-1:0] pad_ctl,
    output logic [7:0]            wr_byte
);

    localparam int         PIDX_W   = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
    localparam logic [7:0] VER_BYTE = {REGION, NO_DISK, 5'b00000};

    hio_dec_t          dec;
    logic [PIDX_W-1:0] pad_sel;
    logic              wr_en;
    logic              rd_en;

    assign wr_en    = hst_valid &  hst_write;
    assign rd_en    = hst_valid & ~hst_write;
    assign wr_byte  = (hst_word && dec.hi_byte) ? hst_wdata[15:8] : hst_wdata[7:0];
    assign ram_addr = hst_addr[RAM_AW-1:0];
    assign snd_port = dec.port;
    assign ram_re   = rd_en && dec.tgt == TG_RAM;
    assign ram_we   = wr_en && dec.tgt == TG_RAM;
    assign snd_re   = rd_en && dec.tgt == TG_SND;
    assign snd_we   = wr_en && dec.tgt == TG_SND;
    assign bank_we  = wr_en && dec.tgt == TG_BANK;

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        assign pad_re[g] = rd_en && dec.tgt == TG_PDATA && pad_sel == PIDX_W'(g);
        assign pad_we[g] = wr_en && dec.tgt == TG_PDATA && pad_sel == PIDX_W'(g);
    end

    hio_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_PADS(NUM_PADS),
        .PIDX_W  (PIDX_W)
    ) u_dec (
        .addr   (hst_addr),
        .busack (cop_busack),
        .dec    (dec),
        .pad_sel(pad_sel)
    );

    hio_ctrl_regs #(
        .NUM_PADS(NUM_PADS),
        .PIDX_W  (PIDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .tgt     (dec.tgt),
        .pad_sel (pad_sel),
        .wr_byte (wr_byte),
        .busreq  (cop_busreq),
        .cop_rst (cop_reset),
        .ctl_flat(pad_ctl)
    );

    hio_read_path #(
        .NUM_PADS(NUM_PADS),
        .PIDX_W  (PIDX_W),
        .VER_BYTE(VER_BYTE)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .word      (hst_word),
        .tgt       (dec.tgt),
        .mirror    (dec.mirror),
        .pad_sel   (pad_sel),
        .ram_rdata (ram_rdata),
        .snd_status(snd_status),
        .pad_rdata (pad_rdata),
        .ctl_flat  (pad_ctl),
        .busack    (cop_busack),
        .cop_rst   (cop_reset),
        .rdata     (hst_rdata),
        .rvalid    (hst_rvalid)
    );

endmodule

// File: rtl/hio_decoder_chk.sv
// Checker for hio_decoder, attached by bind; observes ports only.
// Assumes: synchronous active-low reset on rst_n.
module hio_decoder_chk #(
    parameter int ADDR_W   = 17,
    parameter int NUM_PADS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hst_valid,
    input logic                hst_write,
    input logic                hst_word,
    input logic [ADDR_W-1:0]   hst_addr,
    input logic [15:0]         hst_rdata,
    input logic                hst_rvalid,
    input logic                cop_busack,
    input logic                cop_busreq,
    input logic                cop_reset,
    input logic                ram_re,
    input logic                ram_we,
    input logic                snd_re,
    input logic                snd_we,
    input logic                bank_we,
    input logic [NUM_PADS-1:0] pad_re,
    input logic [NUM_PADS-1:0] pad_we
);

    logic [2*NUM_PADS+4:0] strobes;
    logic                  cop_area;
    assign strobes  = {ram_re, ram_we, snd_re, snd_we, bank_we, pad_re, pad_we};
    assign cop_area = (hst_addr[ADDR_W-1:16] == '0);

    a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_valid |-> strobes == '0);

    a_r2_no_grant_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cop_busack |-> !(ram_re | ram_we | snd_re | snd_we | bank_we));

    a_r2_gated_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_valid && !hst_write && !hst_word && cop_area && !cop_busack)
        |=> hst_rdata == 16'h00FF);

    a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_valid && !hst_write) |=> hst_rvalid);

    a_r9_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_valid && !hst_write) |=> !hst_rvalid);

    a_r7_busreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_valid && hst_write) |=> $stable(cop_busreq));

    a_r8_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_valid && hst_write) |=> $stable(cop_reset));

endmodule

bind hio_decoder hio_decoder_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_PADS(NUM_PADS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_valid (hst_valid),
    .hst_write (hst_write),
    .hst_word  (hst_word),
    .hst_addr  (hst_addr),
    .hst_rdata (hst_rdata),
    .hst_rvalid(hst_rvalid),
    .cop_busack(cop_busack),
    .cop_busreq(cop_busreq),
    .cop_reset (cop_reset),
    .ram_re    (ram_re),
    .ram_we    (ram_we),
    .snd_re    (snd_re),
    .snd_we    (snd_we),
    .bank_we   (bank_we),
    .pad_re    (pad_re),
    .pad_we    (pad_we)
);

// File: tb/sim_hio_decoder.sv
`timescale 1ns/1ps
// Bench for hio_decoder: vector table walk, then directed register and corner tests.
module sim_hio_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_valid = 1'b0;
    logic        hst_write = 1'b0;
    logic        hst_word = 1'b0;
    logic [16:0] hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        hst_rvalid;
    logic        cop_busack = 1'b0;
    logic        cop_busreq, cop_reset;
    logic        ram_re, ram_we, snd_re, snd_we, bank_we;
    logic [12:0] ram_addr;
    logic [7:0]  ram_rdata;
    logic [1:0]  snd_port;
    logic [7:0]  snd_status;
    logic [2:0]  pad_re, pad_we;
    logic [23:0] pad_rdata;
    logic [23:0] pad_ctl;
    logic [7:0]  wr_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Models of the external devices' read data.
    assign ram_rdata  = ram_addr[7:0] ^ 8'h5A;
    assign snd_status = 8'h81;
    assign pad_rdata  = 24'h332211;

    hio_decoder u0 (
        .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
        .hst_word(hst_word), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .cop_busack(cop_busack),
        .cop_busreq(cop_busreq), .cop_reset(cop_reset), .ram_re(ram_re),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .snd_re(snd_re), .snd_we(snd_we), .snd_port(snd_port),
        .snd_status(snd_status), .bank_we(bank_we), .pad_re(pad_re),
        .pad_we(pad_we), .pad_rdata(pad_rdata), .pad_ctl(pad_ctl),
        .wr_byte(wr_byte)
    );

    // Strobe code: {ram_we, ram_re, snd_we, snd_re, bank_we, any pad_we, any pad_re}
    localparam logic [6:0] S_RW = 7'h40, S_RR = 7'h20, S_SW = 7'h10, S_SR = 7'h08,
                           S_BK = 7'h04, S_PW = 7'h02, S_PR = 7'h01, S_NO = 7'h00;

    typedef struct packed {
        logic        wr;
        logic        word;
        logic        ack;
        logic [16:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp_rd;
        logic [6:0]  exp_strb;
        logic [1:0]  exp_port;
        logic [7:0]  exp_wb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b0,1'b1,17'h00123,16'h0000,16'h0079,S_RR,2'd0,8'h00,4'd1},  // R1 RAM byte read
        '{1'b0,1'b1,1'b1,17'h0A123,16'h0000,16'h7979,S_RR,2'd0,8'h00,4'd9},  // R9 mirror + 13-bit mask
        '{1'b0,1'b0,1'b0,17'h00123,16'h0000,16'h00FF,S_NO,2'd0,8'h00,4'd2},  // R2 no grant
        '{1'b0,1'b1,1'b0,17'h04000,16'h0000,16'hFFFF,S_NO,2'd0,8'h00,4'd2},  // R2 word, no grant
        '{1'b1,1'b0,1'b0,17'h00010,16'h0055,16'h0000,S_NO,2'd0,8'h00,4'd2},  // R2 write dropped
        '{1'b1,1'b0,1'b1,17'h01FFF,16'h0055,16'h0000,S_RW,2'd0,8'h55,4'd1},  // R1 RAM write
        '{1'b1,1'b1,1'b1,17'h00123,16'hABCD,16'h0000,S_RW,2'd0,8'hAB,4'd10}, // R10 upper byte
        '{1'b1,1'b0,1'b1,17'h04001,16'h0011,16'h0000,S_SW,2'd2,8'h11,4'd3},  // R3 data port
        '{1'b1,1'b0,1'b1,17'h05FFE,16'h0022,16'h0000,S_SW,2'd1,8'h22,4'd3},  // R3 part-2 addr
        '{1'b1,1'b0,1'b1,17'h04004,16'h0033,16'h0000,S_SW,2'd0,8'h33,4'd3},  // R3 part-1 addr
        '{1'b0,1'b0,1'b1,17'h05FFF,16'h0000,16'h0081,S_SR,2'd0,8'h00,4'd3},  // R3 status read
        '{1'b1,1'b0,1'b1,17'h06000,16'h0001,16'h0000,S_BK,2'd0,8'h01,4'd4},  // R4 bank
        '{1'b1,1'b0,1'b1,17'h0E000,16'h0000,16'h0000,S_BK,2'd0,8'h00,4'd4},  // R4 mirrored bank
        '{1'b1,1'b0,1'b1,17'h06002,16'h0001,16'h0000,S_NO,2'd0,8'h00,4'd4},  // R4 near miss
        '{1'b0,1'b0,1'b1,17'h06000,16'h0000,16'h00FF,S_NO,2'd0,8'h00,4'd4},  // R4 bank not readable
        '{1'b0,1'b0,1'b0,17'h10000,16'h0000,16'h00A0,S_NO,2'd0,8'h00,4'd6},  // R6 version
        '{1'b0,1'b1,1'b0,17'h10001,16'h0000,16'hA0A0,S_NO,2'd0,8'h00,4'd9},  // R9 I/O mirror
        '{1'b0,1'b0,1'b0,17'h10003,16'h0000,16'h0011,S_PR,2'd0,8'h00,4'd5},  // R5 pad 0 data
        '{1'b0,1'b0,1'b0,17'h12007,16'h0000,16'h0033,S_PR,2'd0,8'h00,4'd5},  // R5 pad 2, 13-bit mask
        '{1'b0,1'b0,1'b0,17'h1000E,16'h0000,16'h00FF,S_NO,2'd0,8'h00,4'd5},  // R5 index 7
        '{1'b0,1'b1,1'b0,17'h10200,16'h0000,16'hFF00,S_NO,2'd0,8'h00,4'd12}, // R12 unmapped word
        '{1'b1,1'b1,1'b0,17'h10005,16'h77C3,16'h0000,S_PW,2'd0,8'hC3,4'd10}, // R10 lower byte
        '{1'b1,1'b0,1'b0,17'h10041,16'h0001,16'h0000,S_NO,2'd0,8'h00,4'd12}, // R12 unmapped write
        '{1'b0,1'b1,1'b1,17'h10003,16'h0000,16'h1111,S_PR,2'd0,8'h00,4'd9}   // R9 pad word
    };

    logic [6:0]  c_strb;
    logic [1:0]  c_port;
    logic [7:0]  c_wb;
    logic [2:0]  c_padwe;
    logic [15:0] c_rd;
    logic        c_rv;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One host access: drive at a falling edge, capture strobes mid-cycle, read data after the edge.
    task automatic access(input logic wr, input logic word, input logic ack,
                          input logic [16:0] addr, input logic [15:0] wd);
        @(negedge clk);
        hst_valid = 1'b1; hst_write = wr; hst_word = word;
        hst_addr = addr; hst_wdata = wd; cop_busack = ack;
        #1;
        c_strb  = {ram_we, ram_re, snd_we, snd_re, bank_we, |pad_we, |pad_re};
        c_port  = snd_port;
        c_wb    = wr_byte;
        c_padwe = pad_we;
        @(negedge clk);
        hst_valid = 1'b0;
        c_rd = hst_rdata;
        c_rv = hst_rvalid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        check("R11 busreq", cop_busreq, 0);
        check("R11 reset", cop_reset, 1);
        check("R11 pad_ctl", pad_ctl, 0);
        check("R11 rvalid", hst_rvalid, 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            access(VT[i].wr, VT[i].word, VT[i].ack, VT[i].addr, VT[i].wdata);
            check($sformatf("R%0d strobes v%0d", VT[i].req, i), c_strb, VT[i].exp_strb);
            if (VT[i].wr) begin
                if (VT[i].exp_strb != S_NO)
                    check($sformatf("R%0d wr_byte v%0d", VT[i].req, i), c_wb, VT[i].exp_wb);
                if (VT[i].exp_strb == S_SW)
                    check($sformatf("R%0d snd_port v%0d", VT[i].req, i), c_port, VT[i].exp_port);
                check($sformatf("R%0d no rvalid v%0d", VT[i].req, i), c_rv, 0);
            end else begin
                check($sformatf("R%0d rdata v%0d", VT[i].req, i), c_rd, VT[i].exp_rd);
                check($sformatf("R%0d rvalid v%0d", VT[i].req, i), c_rv, 1);
            end
        end

        // R5 pad strobe position: index 2 is controller 1
        access(1'b1, 1'b0, 1'b0, 17'h10005, 16'h0009);
        check("R5 pad_we onehot", c_padwe, 3'b010);

        // R7 bus request register
        access(1'b1, 1'b0, 1'b0, 17'h11100, 16'h0001);
        check("R7 busreq set", cop_busreq, 1);
        access(1'b0, 1'b0, 1'b0, 17'h11100, 16'h0000);
        check("R7 read no ack", c_rd, 16'h0001);
        access(1'b0, 1'b0, 1'b1, 17'h11100, 16'h0000);
        check("R7 read ack", c_rd, 16'h0000);
        access(1'b0, 1'b1, 1'b0, 17'h11100, 16'h0000);
        check("R9 word upper only", c_rd, 16'h0100);
        access(1'b1, 1'b1, 1'b0, 17'h11100, 16'h00FF);
        check("R10 word uses upper byte", cop_busreq, 0);
        access(1'b1, 1'b1, 1'b0, 17'h11100, 16'h0100);
        check("R10 word upper sets", cop_busreq, 1);
        access(1'b1, 1'b0, 1'b0, 17'h11100, 16'h0000);
        check("R7 busreq clear", cop_busreq, 0);

        // R8 coprocessor reset register
        access(1'b0, 1'b0, 1'b0, 17'h11200, 16'h0000);
        check("R8 read held", c_rd, 16'h0000);
        access(1'b1, 1'b0, 1'b0, 17'h11200, 16'h0001);
        check("R8 release", cop_reset, 0);
        access(1'b0, 1'b0, 1'b0, 17'h11200, 16'h0000);
        check("R8 read released", c_rd, 16'h0001);
        access(1'b1, 1'b0, 1'b0, 17'h11200, 16'h00FE);
        check("R8 assert", cop_reset, 1);

        // R5 control registers
        access(1'b1, 1'b0, 1'b0, 17'h1000D, 16'h005A);
        check("R5 ctl pad2", pad_ctl, 24'h5A0000);
        access(1'b1, 1'b0, 1'b0, 17'h10009, 16'h00C4);
        check("R5 ctl pad0", pad_ctl, 24'h5A00C4);
        access(1'b0, 1'b0, 1'b0, 17'h1000D, 16'h0000);
        check("R5 ctl readback", c_rd, 16'h005A);
        access(1'b0, 1'b1, 1'b0, 17'h10009, 16'h0000);
        check("R9 ctl word mirror", c_rd, 16'hC4C4);

        // R12 unmapped I/O write leaves everything alone
        access(1'b1, 1'b0, 1'b0, 17'h11300, 16'h0001);
        check("R12 no strobe", c_strb, 7'h00);
        check("R12 busreq kept", cop_busreq, 0);
        check("R12 reset kept", cop_reset, 1);
        check("R12 ctl kept", pad_ctl, 24'h5A00C4);
        access(1'b0, 1'b0, 1'b0, 17'h11300, 16'h0000);
        check("R12 unmapped read", c_rd, 16'h00FF);

        // R13 idle cycle: no strobes, no rvalid
        @(negedge clk);
        #1;
        check("R13 idle strobes", {ram_we, ram_re, snd_we, snd_re, bank_we, |pad_we, |pad_re}, 7'h00);
        check("R13 idle rvalid", hst_rvalid, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule